// File: doc/BRIEF.md
# Function-to-GPIO Pin Router

This block places a set of on-chip peripheral signals ("functions") onto a window of 64 GPIO pads. Each function owns a 7-bit selector that names the pad it is routed to. Two selectors share each 32-bit configuration word, and every selector bit has its own write-enable bit in the same word. Software can therefore change one selector, or part of one, without a read-modify-write of its neighbour.

On the pad side, a routed function supplies the pad's output value and output enable. The function also receives the pad's input value back. A per-pad ownership flag from the pad control bank says whether the pad is currently given to this router. A pad that is not owned by the router is never driven by it.

All outputs are registered. Pad outputs and function inputs follow their inputs and the stored selectors with one clock of latency. Configuration read data appears one clock after the address.

Top module: `fnrt_top`

## Requirements
- R1: Function f lives in word f/2. An even f stores its selector in bits 6:0, with write-enable bits 22:16. An odd f stores its selector in bits 14:8, with write-enable bits 30:24.
- R2: A selector bit changes on a write only when its own write-enable bit is 1 in that same write; a write with all write-enable bits 0 leaves the word unchanged.
- R3: Read data for an address is returned on the next clock. It holds the two selectors at the R1 positions and 0 in every other bit. An address at or above NUM_FUNCS/2 reads 0, and a write to it changes no selector.
- R4: After synchronous reset every selector is 0. All pad outputs and enables are 0, and every function input is 0.
- R5: A selector value k in 1..64 routes the function to window pad k-1 (GPIO k+7). One clock later the pad's output equals the function's output, and the pad's enable equals the function's enable.
- R6: A selector of 0 or above 64 leaves the function unmapped. The function drives no pad, and its input output reads 0.
- R7: A pad whose ownership flag is 0 has output and enable 0 on the next clock, whatever selects it.
- R8: When several functions select the same pad, the lowest-numbered one supplies both the pad's output and its enable.
- R9: Every mapped function receives its selected pad's input value one clock later, including when it loses the pad to a lower-numbered function.
- R10: A pad that no function selects has output and enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word index |
| cfg_wdata | input | 32 | Write data: selectors and their write enables |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| fn_out | input | NUM_FUNCS | Output value of each function |
| fn_oe | input | NUM_FUNCS | Output enable of each function |
| fn_in | output | NUM_FUNCS | Input value delivered to each function |
| pad_mux_own | input | NUM_PINS | 1 where the pad is handed to this router |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |

## Verification
A table of configuration writes is read back after each step. The writes use a full write enable for one selector, a full enable for the other, no enable at all, and a partial enable mask. This separates the even and odd field positions and shows bit-level write protection. A write to an out-of-range address is followed by a read of the word it would alias to if address bits were dropped.

Routing is tried with two functions on one pad under opposite output values and enables, which shows which function wins. The first and last window pads are used, along with a selector just past the window. Ownership is withdrawn on a single pad. Pad inputs are applied with a pattern that differs between shared and exclusive pads, which separates delivery to every selecting function from delivery to the driving one only.

// File: rtl/fnrt_pkg.sv
package fnrt_pkg;
  localparam int CTRL_W        = 7;
  localparam int WORD_W        = 32;
  localparam int EVEN_CTRL_LSB = 0;
  localparam int EVEN_MASK_LSB = 16;
  localparam int ODD_CTRL_LSB  = 8;
  localparam int ODD_MASK_LSB  = 24;
  typedef logic [CTRL_W-1:0] sel_t;
endpackage

// File: rtl/fnrt_cfg_regs.sv
module fnrt_cfg_regs
  import fnrt_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [WORD_W-1:0]              cfg_wdata,
  output logic [WORD_W-1:0]              cfg_rdata,
  output logic [NUM_FUNCS-1:0][CTRL_W-1:0] sel_q
);
  localparam int NUM_WORDS = NUM_FUNCS / 2;

  logic [WORD_W-1:0] rd_next;

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
    localparam int CL = (f % 2 == 1) ? ODD_CTRL_LSB : EVEN_CTRL_LSB;
    localparam int ML = (f % 2 == 1) ? ODD_MASK_LSB : EVEN_MASK_LSB;
    logic hit;
    assign hit = cfg_we && (cfg_addr == ADDR_W'(f / 2));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[f] <= '0;
      end else if (hit) begin
        for (int b = 0; b < CTRL_W; b++) begin
          if (cfg_wdata[ML+b]) sel_q[f][b] <= cfg_wdata[CL+b];
        end
      end
    end

    // R2: a write with an empty write-enable field leaves the selector alone
    assert_masked_write_R2: assert property (@(posedge clk) disable iff (rst)
      (hit && cfg_wdata[ML+CTRL_W-1:ML] == '0) |=> $stable(sel_q[f]));
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (cfg_addr == ADDR_W'(w)) begin
        rd_next[EVEN_CTRL_LSB +: CTRL_W] = sel_q[2*w];
        rd_next[ODD_CTRL_LSB  +: CTRL_W] = sel_q[2*w+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  // R3: writes outside the implemented words touch no selector
  assert_oob_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) >= NUM_WORDS) |=> $stable(sel_q));
endmodule

// File: rtl/fnrt_pad_drive.sv
module fnrt_pad_drive
  import fnrt_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_PINS  = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_FUNCS-1:0][CTRL_W-1:0] sel_q,
  input  logic [NUM_FUNCS-1:0]             fn_out,
  input  logic [NUM_FUNCS-1:0]             fn_oe,
  input  logic [NUM_PINS-1:0]              pad_mux_own,
  output logic [NUM_PINS-1:0]              pad_out,
  output logic [NUM_PINS-1:0]              pad_oe
);
  logic [NUM_PINS-1:0] out_n, oe_n;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      out_n[p] = 1'b0;
      oe_n[p]  = 1'b0;
      // highest index first, so the lowest-numbered match is the last write
      for (int f = NUM_FUNCS - 1; f >= 0; f--) begin
        if (sel_q[f] == CTRL_W'(p + 1)) begin
          out_n[p] = fn_out[f];
          oe_n[p]  = fn_oe[f];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= out_n & pad_mux_own;
      pad_oe  <= oe_n & pad_mux_own;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_unowned_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      !pad_mux_own[p] |=> (!pad_oe[p] && !pad_out[p]));
  end
endmodule

// File: rtl/fnrt_fn_capture.sv
module fnrt_fn_capture
  import fnrt_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_PINS  = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_FUNCS-1:0][CTRL_W-1:0] sel_q,
  input  logic [NUM_PINS-1:0]              pad_in,
  output logic [NUM_FUNCS-1:0]             fn_in
);
  localparam int PIDX_W = $clog2(NUM_PINS);

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
    logic              mapped;
    logic [PIDX_W-1:0] idx;
    assign mapped = (sel_q[f] != '0) && (sel_q[f] <= CTRL_W'(NUM_PINS));
    assign idx    = PIDX_W'(sel_q[f] - CTRL_W'(1));

    always_ff @(posedge clk) begin
      if (rst)         fn_in[f] <= 1'b0;
      else if (mapped) fn_in[f] <= pad_in[idx];
      else             fn_in[f] <= 1'b0;
    end

    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (sel_q[f] == '0 || sel_q[f] > CTRL_W'(NUM_PINS)) |=> !fn_in[f]);
  end
endmodule

// File: rtl/fnrt_top.sv
module fnrt_top
  import fnrt_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int NUM_PINS  = 64,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  output logic [NUM_FUNCS-1:0] fn_in,
  input  logic [NUM_PINS-1:0]  pad_mux_own,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe
);
  logic [NUM_FUNCS-1:0][CTRL_W-1:0] sel_q;

  fnrt_cfg_regs #(.NUM_FUNCS(NUM_FUNCS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_q(sel_q)
  );

  fnrt_pad_drive #(.NUM_FUNCS(NUM_FUNCS), .NUM_PINS(NUM_PINS)) u_drive (
    .clk(clk), .rst(rst), .sel_q(sel_q), .fn_out(fn_out), .fn_oe(fn_oe),
    .pad_mux_own(pad_mux_own), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  fnrt_fn_capture #(.NUM_FUNCS(NUM_FUNCS), .NUM_PINS(NUM_PINS)) u_cap (
    .clk(clk), .rst(rst), .sel_q(sel_q), .pad_in(pad_in), .fn_in(fn_in)
  );
endmodule

// File: tb/fnrt_top_test.sv
module fnrt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int NP = 64;
  localparam int AW = 4;
  localparam int NVEC = 8;

  // {addr, write data, expected read-back of that address}
  localparam logic [67:0] VEC [NVEC] = '{
    {4'h0, 32'h007F0005, 32'h00000005},
    {4'h0, 32'h7F000A00, 32'h00000A05},
    {4'h0, 32'h00007F7F, 32'h00000A05},
    {4'h0, 32'h0003007C, 32'h00000A04},
    {4'h1, 32'h7F7F2141, 32'h00002141},
    {4'h9, 32'h7F7F1111, 32'h00000000},
    {4'h1, 32'h00000000, 32'h00002141},
    {4'h3, 32'hFFFFFFFF, 32'h00007F7F}
  };

  logic clk = 0, rst = 1, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NF-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [NP-1:0] pad_mux_own = '0, pad_in = '0, pad_out, pad_oe;
  int total = 0, bad = 0;

  fnrt_top #(.NUM_FUNCS(NF), .NUM_PINS(NP), .ADDR_W(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); cfg_addr = a;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pad_mux_own = '1; fn_oe = '1; fn_out = '1; pad_in = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0);
    check("R4 reset readback", 64'(cfg_rdata), 64'h0);
    check("R4 reset pad_oe", pad_oe, 64'h0);
    check("R4 reset pad_out", pad_out, 64'h0);
    check("R4 reset fn_in", 64'(fn_in), 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      @(negedge clk);
      check($sformatf("table vector %0d R1 R2 R3", i), 64'(cfg_rdata), 64'(VEC[i][31:0]));
    end

    // routing: f0,f1 -> pad2; f2,f3 -> pad63; f4 -> pad0; f5,f6 off; f7=65 off
    wr(0, 32'h7F7F0303);
    wr(1, 32'h7F7F4040);
    wr(2, 32'h7F7F0001);
    wr(3, 32'h7F7F4100);
    fn_oe = '1; fn_out = 8'b0000_0110; pad_in = '0;
    @(negedge clk); @(negedge clk);
    check("R5 R10 R6 pad_oe map", pad_oe, 64'h8000000000000005);
    check("R8 R5 pad_out low wins", pad_out, 64'h8000000000000000);
    fn_out = 8'b0001_0001;
    @(negedge clk);
    check("R8 R5 pad_out flip", pad_out, 64'h0000000000000005);
    fn_oe = 8'b1111_1110;
    @(negedge clk);
    check("R8 enable from lowest", pad_oe, 64'h8000000000000001);
    fn_oe = '1; pad_mux_own[2] = 1'b0;
    @(negedge clk);
    check("R7 unowned pad_oe", pad_oe, 64'h8000000000000001);
    check("R7 unowned pad_out", pad_out, 64'h0000000000000001);
    pad_in = 64'h8000000000000004;
    @(negedge clk);
    check("R9 fn_in shared pads", 64'(fn_in), 64'h0F);
    pad_in = '1;
    @(negedge clk);
    check("R9 R6 fn_in all high", 64'(fn_in), 64'h1F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule